// File: doc/BRIEF.md
# Divide Ratio to Jam-Preset Encoder

This block turns a requested division ratio and a choice of first-stage prescaler into the programming word of a presettable divide-by-N down-counter: sixteen preset (jam) bits and three mode-select levels. It divides the ratio by the prescaler value. The remainder becomes the first-stage preset. The quotient is expanded into decimal digits: the units, tens and hundreds digits load the three BCD decades, and the thousands digit loads whatever preset bits the first stage leaves free.

The work runs over several clocks. A restoring divider is followed by an iterative binary-to-BCD converter. A one-cycle start pulse launches a request, and a one-cycle done pulse marks the moment the outputs carry the new word. Those outputs then hold until the next request completes. Requests outside the legal range, or that do not fit the selected prescaler, raise a range error and produce an all-zero word.

Top module: `ratio_preset_enc`

## Requirements
- R1: After reset, `jam`, `psel`, `done` and `range_err` are all zero.
- R2: When the request is legal, the low `rb` bits of `jam` hold N mod D. D and `rb` depend on the `mode` code: code 0 gives D=2 and rb=1; code 1 gives D=4 and rb=2; code 2 gives D=5 and rb=3; code 3 gives D=8 and rb=3; code 4 gives D=10 and rb=4.
- R3: When the request is legal, the units, tens and hundreds digits of N/D appear in BCD on `jam[7:4]`, `jam[11:8]` and `jam[15:12]`, least significant bit lowest.
- R4: When the request is legal, the thousands digit of N/D appears on `jam[3:rb]`. This field is empty for code 4.
- R5: `psel` = {first, second, third} select level. It is 3'b111 for code 0, 3'b011 for code 1, 3'b101 for code 2, 3'b001 for code 3 and 3'b110 for code 4.
- R6: A request sets `range_err` and drives `jam` and `psel` to zero in any of these cases: N < 3; N > 9999 with code 2 or 4; N > 15999 with codes 0, 1 or 3; a `mode` code of 5 to 7; or a thousands digit above the free capacity (7, 3, 1, 1, 0 for codes 0 to 4).
- R7: Each accepted start produces exactly one `done` pulse, one cycle wide. `jam`, `psel` and `range_err` change only in that cycle and hold afterwards.
- R8: A `start` that arrives while a conversion is running is ignored. It produces no extra `done`, and the result belongs to the earlier request.
- R9: N = 8479 with code 2 yields `jam` = 16'h695C and `psel` = 3'b101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| ratio | input | NW (14) | Requested division ratio N |
| mode | input | 3 | Prescaler code 0..4 |
| jam | output | 16 | Preset bits, bit 0 is the first preset input |
| psel | output | 3 | Mode-select levels {first, second, third} |
| done | output | 1 | One-cycle pulse: new word present |
| range_err | output | 1 | Last request was rejected |

## Verification
The assertions assume that `ratio` and `mode` matter only in the cycle a start is accepted. They also assume that every legal mode code maps to a non-zero divisor, so that the bound on the divider remainder is meaningful. The stimulus changes inputs only on the falling clock edge and holds `start` for exactly one cycle, except in the busy scenario, where it is deliberately held high while a conversion runs. It waits for `done` before checking any result.

// File: rtl/rpe_pkg.sv
`timescale 1ns/1ps
package rpe_pkg;

   typedef enum logic [2:0] {
      MD_BY2  = 3'd0,
      MD_BY4  = 3'd1,
      MD_BY5  = 3'd2,
      MD_BY8  = 3'd3,
      MD_BY10 = 3'd4
   } pmode_e;

   function automatic logic mode_ok(logic [2:0] m);
      return m <= 3'd4;
   endfunction

   function automatic logic [3:0] divisor_of(logic [2:0] m);
      case (m)
         MD_BY2:  return 4'd2;
         MD_BY4:  return 4'd4;
         MD_BY5:  return 4'd5;
         MD_BY8:  return 4'd8;
         MD_BY10: return 4'd10;
         default: return 4'd2;
      endcase
   endfunction

   // width of the first-stage remainder field
   function automatic logic [2:0] rem_bits(logic [2:0] m);
      case (m)
         MD_BY2:  return 3'd1;
         MD_BY4:  return 3'd2;
         MD_BY5:  return 3'd3;
         MD_BY8:  return 3'd3;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [3:0] thou_cap(logic [2:0] m);
      case (m)
         MD_BY2:  return 4'd7;
         MD_BY4:  return 4'd3;
         MD_BY5:  return 4'd1;
         MD_BY8:  return 4'd1;
         default: return 4'd0;
      endcase
   endfunction

   function automatic logic [2:0] psel_of(logic [2:0] m);
      case (m)
         MD_BY2:  return 3'b111;
         MD_BY4:  return 3'b011;
         MD_BY5:  return 3'b101;
         MD_BY8:  return 3'b001;
         MD_BY10: return 3'b110;
         default: return 3'b000;
      endcase
   endfunction

   // decimal digits needed for the largest quotient (divisor >= 2), at least 4
   function automatic int dec_digits(int w);
      int v;
      int n;
      v = ((1 << w) - 1) / 2;
      n = 1;
      while (v >= 10) begin
         v = v / 10;
         n++;
      end
      return (n < 4) ? 4 : n;
   endfunction

endpackage

// File: rtl/rpe_div.sv
`timescale 1ns/1ps
module rpe_div #(
   parameter int NW = 14,
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [NW-1:0] dividend,
   input  logic [DW-1:0] divisor,
   output logic          fin,
   output logic [NW-1:0] quo,
   output logic [DW-1:0] rem
);
   localparam int CW = $clog2(NW + 1);

   if (NW < 4)  begin : g_bad_nw  $error("rpe_div: NW too small");  end
   if (DW < 2)  begin : g_bad_dw  $error("rpe_div: DW too small");  end

   logic [DW-1:0] acc, dv_q;
   logic [NW-1:0] sh;
   logic [CW-1:0] cnt;
   logic          run;
   logic [DW:0]   trial;
   logic          ge;

   assign trial = {acc, sh[NW-1]};
   assign ge    = trial >= {1'b0, dv_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         dv_q <= '0;
         sh   <= '0;
         cnt  <= '0;
         run  <= 1'b0;
         fin  <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            acc  <= '0;
            sh   <= dividend;
            dv_q <= divisor;
            cnt  <= CW'(NW);
            run  <= 1'b1;
         end else if (run) begin
            acc <= ge ? DW'(trial - {1'b0, dv_q}) : trial[DW-1:0];
            sh  <= {sh[NW-2:0], ge};
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   assign quo = sh;
   assign rem = acc;

   // R2: the remainder handed on is always below the divisor
   p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (rem < dv_q));
   p_cnt_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt != '0));
endmodule

// File: rtl/rpe_bcd.sv
`timescale 1ns/1ps
module rpe_bcd #(
   parameter int W  = 14,
   parameter int ND = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [W-1:0]    bin,
   output logic            fin,
   output logic [4*ND-1:0] dig
);
   localparam int CW = $clog2(W + 1);

   if (W < 2)  begin : g_bad_w  $error("rpe_bcd: W too small");  end
   if (ND < 1) begin : g_bad_nd $error("rpe_bcd: ND too small"); end

   logic [4*ND-1:0] dg, adj;
   logic [W-1:0]    sh;
   logic [CW-1:0]   cnt;
   logic            run;

   for (genvar gi = 0; gi < ND; gi++) begin : g_dig
      assign adj[4*gi +: 4] = (dg[4*gi +: 4] >= 4'd5) ? dg[4*gi +: 4] + 4'd3
                                                       : dg[4*gi +: 4];
      // R3: every finished digit is a legal BCD value
      p_digit_bcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
         fin |-> (dig[4*gi +: 4] <= 4'd9));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dg  <= '0;
         sh  <= '0;
         cnt <= '0;
         run <= 1'b0;
         fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            dg  <= '0;
            sh  <= bin;
            cnt <= CW'(W);
            run <= 1'b1;
         end else if (run) begin
            dg  <= {adj[4*ND-2:0], sh[W-1]};
            sh  <= {sh[W-2:0], 1'b0};
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   assign dig = dg;
endmodule

// File: rtl/ratio_preset_enc.sv
`timescale 1ns/1ps
module ratio_preset_enc
   import rpe_pkg::*;
#(
   parameter int NW      = 14,
   parameter int LO_LIM  = 3,
   parameter int DEC_LIM = 9999,
   parameter int BIN_LIM = 15999
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NW-1:0] ratio,
   input  logic [2:0]    mode,
   output logic [15:0]   jam,
   output logic [2:0]    psel,
   output logic          done,
   output logic          range_err
);
   localparam int ND = dec_digits(NW);
   localparam int DW = 4;

   if (NW < 4 || NW > 24)     begin : g_bad_nw  $error("ratio_preset_enc: NW out of range"); end
   if (BIN_LIM >= (1 << NW))  begin : g_bad_lim $error("ratio_preset_enc: BIN_LIM exceeds ratio width"); end
   if (DEC_LIM > BIN_LIM)     begin : g_bad_dec $error("ratio_preset_enc: DEC_LIM above BIN_LIM"); end

   typedef enum logic [1:0] {S_IDLE, S_DIV, S_BCD} st_e;
   st_e st;

   logic [NW-1:0]   n_q;
   logic [2:0]      m_q;
   logic            div_go, div_fin, bcd_fin;
   logic [NW-1:0]   quo;
   logic [DW-1:0]   rem;
   logic [4*ND-1:0] dig;
   logic [3:0]      thou, low4;
   logic            hi_nz, bad;
   logic [31:0]     lim;

   assign div_go = start && (st == S_IDLE);

   rpe_div #(.NW(NW), .DW(DW)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(ratio),
      .divisor(divisor_of(mode)), .fin(div_fin), .quo(quo), .rem(rem));

   rpe_bcd #(.W(NW), .ND(ND)) u_bcd (
      .clk(clk), .rst_n(rst_n), .go(div_fin), .bin(quo),
      .fin(bcd_fin), .dig(dig));

   assign thou = dig[15:12];
   if (ND > 4) begin : g_hi
      assign hi_nz = |dig[4*ND-1:16];
   end else begin : g_nohi
      assign hi_nz = 1'b0;
   end

   // R6: legality of the request, judged on the captured ratio and mode
   always_comb begin
      lim = (m_q == MD_BY5 || m_q == MD_BY10) ? 32'(DEC_LIM) : 32'(BIN_LIM);
      bad = !mode_ok(m_q) || (32'(n_q) < 32'(LO_LIM)) || (32'(n_q) > lim)
            || hi_nz || (thou > thou_cap(m_q));
   end

   // R2, R4: remainder in the low bits, thousands above it
   assign low4 = rem | 4'(thou << rem_bits(m_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         n_q       <= '0;
         m_q       <= '0;
         jam       <= '0;
         psel      <= '0;
         done      <= 1'b0;
         range_err <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            S_IDLE: if (div_go) begin
               n_q <= ratio;
               m_q <= mode;
               st  <= S_DIV;
            end
            S_DIV: if (div_fin) st <= S_BCD;
            S_BCD: if (bcd_fin) begin
               st   <= S_IDLE;
               done <= 1'b1;
               if (bad) begin
                  jam       <= '0;
                  psel      <= '0;
                  range_err <= 1'b1;
               end else begin
                  jam       <= {dig[11:0], low4};   // R3: hundreds, tens, units
                  psel      <= psel_of(m_q);        // R5
                  range_err <= 1'b0;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bcd_fin |=> ($stable(jam) && $stable(psel) && $stable(range_err)));
   p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && range_err) |-> (jam == 16'h0 && psel == 3'b000));
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE) |=> ($stable(n_q) && $stable(m_q)));
   p_sel_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !range_err) |-> (psel != 3'b000 && psel != 3'b010 && psel != 3'b100));
endmodule

// File: tb/sim_ratio_preset_enc.sv
`timescale 1ns/1ps
module sim_ratio_preset_enc;
   localparam int NW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NW-1:0] ratio = '0;
   logic [2:0]    mode = '0;
   logic [15:0]   jam;
   logic [2:0]    psel;
   logic          done;
   logic          range_err;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   ratio_preset_enc #(.NW(NW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .ratio(ratio), .mode(mode),
      .jam(jam), .psel(psel), .done(done), .range_err(range_err));

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // independent model of the requirements
   function automatic logic [19:0] model(input int n, input int m);
      int d, rb, cap, lim, q, r, th;
      logic [15:0] j;
      logic [2:0]  s;
      case (m)
         0: begin d = 2;  rb = 1; cap = 7; lim = 15999; s = 3'b111; end
         1: begin d = 4;  rb = 2; cap = 3; lim = 15999; s = 3'b011; end
         2: begin d = 5;  rb = 3; cap = 1; lim = 9999;  s = 3'b101; end
         3: begin d = 8;  rb = 3; cap = 1; lim = 15999; s = 3'b001; end
         4: begin d = 10; rb = 4; cap = 0; lim = 9999;  s = 3'b110; end
         default: return {1'b1, 3'b000, 16'h0};
      endcase
      if (n < 3 || n > lim) return {1'b1, 3'b000, 16'h0};
      q = n / d; r = n % d; th = q / 1000;
      if (th > cap) return {1'b1, 3'b000, 16'h0};
      j = 16'(r | (th << rb) | ((q % 10) << 4) | (((q / 10) % 10) << 8) | (((q / 100) % 10) << 12));
      return {1'b0, s, j};
   endfunction

   task automatic wait_done(input string req);
      int n;
      n = 0;
      while (!done && n < 300) begin
         @(negedge clk);
         n++;
      end
      chk(done, {req, " done seen"}, 32'(done), 32'd1);
   endtask

   task automatic run(input int n, input int m, input string req);
      logic [19:0] e;
      e = model(n, m);
      @(negedge clk);
      start = 1'b1; ratio = NW'(n); mode = 3'(m);
      @(negedge clk);
      start = 1'b0;
      wait_done(req);
      chk({range_err, psel, jam} === e, req, 32'({range_err, psel, jam}), 32'(e));
      @(negedge clk);
      chk(done === 1'b0, "R7 done one cycle", 32'(done), 32'd0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({jam, psel, done, range_err} === 21'h0, "R1 reset state",
          32'({jam, psel, done, range_err}), 32'd0);
   endtask

   task automatic t_example();
      run(8479, 2, "R9 example");
      chk(jam === 16'h695C, "R9 jam", 32'(jam), 32'h695C);
      chk(psel === 3'b101, "R9/R5 select", 32'(psel), 32'h5);
   endtask

   task automatic t_modes();
      run(100,   0, "R2/R3/R4/R5 by2");
      run(15999, 0, "R4 by2 thousands 7");
      run(3,     0, "R2 by2 low limit");
      run(12345, 1, "R2/R3/R4 by4");
      run(15999, 1, "R4 by4 thousands 3");
      run(777,   2, "R2/R3 by5");
      run(9999,  2, "R4 by5 top");
      run(9998,  3, "R2/R3/R4 by8");
      run(15999, 3, "R4 by8 top");
      run(9999,  4, "R2/R3 by10 top");
      run(3,     4, "R2 by10 low limit");
      run(10,    4, "R3 by10 tens");
   endtask

   task automatic t_bounds();
      run(2,     0, "R6 below low limit");
      run(0,     3, "R6 zero");
      run(10000, 2, "R6 by5 over");
      run(10000, 4, "R6 by10 over");
      run(16000, 0, "R6 by2 over");
      run(16383, 1, "R6 by4 max input");
      run(500,   5, "R6 bad code 5");
      run(500,   7, "R6 bad code 7");
      chk(range_err === 1'b1, "R6 flag held", 32'(range_err), 32'd1);
   endtask

   task automatic t_hold();
      logic [19:0] snap;
      int extra;
      run(4321, 3, "R7 setup");
      snap = {range_err, psel, jam};
      extra = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk(extra == 0, "R7 no stray done", 32'(extra), 32'd0);
      chk({range_err, psel, jam} === snap, "R7 word held", 32'({range_err, psel, jam}), 32'(snap));
   endtask

   task automatic t_busy();
      logic [19:0] e;
      int extra;
      e = model(1234, 4);
      @(negedge clk);
      start = 1'b1; ratio = NW'(1234); mode = 3'd4;
      @(negedge clk);
      ratio = NW'(4321); mode = 3'd0;   // start kept high while busy
      repeat (3) @(negedge clk);
      start = 1'b0;
      wait_done("R8 first request");
      chk({range_err, psel, jam} === e, "R8 result of first request",
          32'({range_err, psel, jam}), 32'(e));
      extra = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk(extra == 0, "R8 ignored start gave no done", 32'(extra), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_example();
      t_modes();
      t_bounds();
      t_hold();
      t_busy();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule